// File: doc/BRIEF.md
# Conditional Branch Condition Evaluator

This block decides whether a short conditional jump is taken. Each request carries a 4-bit condition code and a snapshot of five status flags: carry, zero, sign, overflow and parity. One clock later the block returns the decision together with the number of execution cycles the branch costs. The cost is one fixed value for a taken branch and another for a branch that falls through.

The sixteen codes are eight base tests, each paired with its negation. Code bits [3:1] pick the base test and code bit 0 inverts it. The base tests cover single flags (overflow, carry, zero, sign, parity) and compound relations. The compound relations are an unsigned compare built from carry and zero, and signed compares built from sign, overflow and zero.

Requests are marked by a valid strobe. The registered result appears with its own valid strobe one cycle later. When no request arrives, the result fields keep their last values.

Top module: `bcc_eval`

## Requirements
- R1: After reset, out_valid, out_taken and out_cycles are all 0.
- R2: out_valid equals the in_valid sampled on the previous rising clock edge, so each result appears exactly one cycle after its request.
- R3: Code 0 is taken when OF = 1, and code 1 is taken when OF = 0.
- R4: Code 2 is taken when CF = 1 (below, or carry set), and code 3 is taken when CF = 0.
- R5: Code 4 is taken when ZF = 1 (equal), and code 5 is taken when ZF = 0.
- R6: Code 6 is taken when CF = 1 or ZF = 1 (unsigned below-or-equal). Code 7 is taken when CF = 0 and ZF = 0 (unsigned above).
- R7: Code 8 is taken when SF = 1, and code 9 is taken when SF = 0.
- R8: Code 10 is taken when PF = 1 (parity even), and code 11 is taken when PF = 0.
- R9: Code 12 is taken when SF differs from OF (signed less). Code 13 is taken when SF equals OF (signed greater-or-equal).
- R10: Code 14 is taken when ZF = 1 or SF differs from OF (signed less-or-equal). Code 15 is taken when ZF = 0 and SF equals OF (signed greater).
- R11: For identical flags, an odd code 2k+1 always gives the opposite decision to the even code 2k.
- R12: out_cycles is 16 with a taken decision and 4 with a not-taken decision.
- R13: A cycle with in_valid low leaves out_taken and out_cycles unchanged, whatever the code and flag inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_cond | input | 4 | Condition code |
| in_cf | input | 1 | Carry flag |
| in_zf | input | 1 | Zero flag |
| in_sf | input | 1 | Sign flag |
| in_of | input | 1 | Overflow flag |
| in_pf | input | 1 | Parity flag |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_taken | output | 1 | 1 when the branch is taken |
| out_cycles | output | 5 | Cycle cost of the branch |

## Verification
The only state is the single result register, so any fault shows up at the ports in the cycle right after the request that caused it. A wrong base-test decode or a lost inversion flips out_taken for some code and flag pattern. The matching out_cycles value then moves between 16 and 4 at the same time. A hold fault shows up only on an idle cycle, where out_taken or out_cycles changes while out_valid stays low. For that reason the bench changes the inputs during idle cycles.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic of;
        logic pf;
    } bcc_flags_t;

    // Base test selected by condition code bits [3:1]
    typedef enum logic [2:0] {
        BASE_OVF   = 3'd0,
        BASE_CARRY = 3'd1,
        BASE_ZERO  = 3'd2,
        BASE_BE    = 3'd3,
        BASE_SIGN  = 3'd4,
        BASE_PAR   = 3'd5,
        BASE_LT    = 3'd6,
        BASE_LE    = 3'd7
    } bcc_base_e;

endpackage

// File: rtl/bcc_flag_test.sv
module bcc_flag_test
    import bcc_pkg::*;
(
    input  bcc_base_e  base,
    input  bcc_flags_t flags,
    output logic       hit
);
    logic sign_ne_ovf;

    always_comb begin
        sign_ne_ovf = flags.sf ^ flags.of;
        unique case (base)
            BASE_OVF:   hit = flags.of;
            BASE_CARRY: hit = flags.cf;
            BASE_ZERO:  hit = flags.zf;
            BASE_BE:    hit = flags.cf | flags.zf;
            BASE_SIGN:  hit = flags.sf;
            BASE_PAR:   hit = flags.pf;
            BASE_LT:    hit = sign_ne_ovf;
            BASE_LE:    hit = flags.zf | sign_ne_ovf;
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcc_cost_sel.sv
module bcc_cost_sel #(
    parameter int unsigned TAKEN_CYCLES    = 16,
    parameter int unsigned NOTTAKEN_CYCLES = 4,
    parameter int unsigned COST_W          = 5
) (
    input  logic              taken,
    output logic [COST_W-1:0] cycles
);
    localparam logic [COST_W-1:0] COST_T  = COST_W'(TAKEN_CYCLES);
    localparam logic [COST_W-1:0] COST_NT = COST_W'(NOTTAKEN_CYCLES);

    always_comb begin
        cycles = taken ? COST_T : COST_NT;
    end
endmodule

// File: rtl/bcc_eval.sv
module bcc_eval
    import bcc_pkg::*;
#(
    parameter int unsigned TAKEN_CYCLES    = 16,
    parameter int unsigned NOTTAKEN_CYCLES = 4,
    localparam int unsigned MAX_COST = (TAKEN_CYCLES > NOTTAKEN_CYCLES) ? TAKEN_CYCLES : NOTTAKEN_CYCLES,
    localparam int unsigned COST_W   = $clog2(MAX_COST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_cond,
    input  logic              in_cf,
    input  logic              in_zf,
    input  logic              in_sf,
    input  logic              in_of,
    input  logic              in_pf,
    output logic              out_valid,
    output logic              out_taken,
    output logic [COST_W-1:0] out_cycles
);
    typedef struct packed {
        logic              valid;
        logic              taken;
        logic [COST_W-1:0] cycles;
    } res_t;

    res_t              res_d, res_q;
    bcc_flags_t        flags_c;
    logic              base_hit;
    logic              taken_c;
    logic [COST_W-1:0] cost_c;

    assign flags_c = '{cf: in_cf, zf: in_zf, sf: in_sf, of: in_of, pf: in_pf};

    bcc_flag_test u_test (
        .base  (bcc_base_e'(in_cond[3:1])),
        .flags (flags_c),
        .hit   (base_hit)
    );

    // Bit 0 of the code inverts the base test
    assign taken_c = base_hit ^ in_cond[0];

    bcc_cost_sel #(
        .TAKEN_CYCLES    (TAKEN_CYCLES),
        .NOTTAKEN_CYCLES (NOTTAKEN_CYCLES),
        .COST_W          (COST_W)
    ) u_cost (
        .taken  (taken_c),
        .cycles (cost_c)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.taken  = taken_c;
            res_d.cycles = cost_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid  = res_q.valid;
    assign out_taken  = res_q.taken;
    assign out_cycles = res_q.cycles;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_OVF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cond == 4'd0) |=> (out_taken == $past(in_of))); // R3
    AST_SIGNED_LESS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cond == 4'd12) |=> (out_taken == ($past(in_sf) != $past(in_of)))); // R9
    AST_COST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_taken) |-> (out_cycles == COST_W'(TAKEN_CYCLES))); // R12
    AST_COST_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_taken) |-> (out_cycles == COST_W'(NOTTAKEN_CYCLES))); // R12
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_taken) && $stable(out_cycles))); // R13
endmodule

// File: tb/bcc_eval_tb_top.sv
module bcc_eval_tb_top;
    localparam int COST_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [3:0]        in_cond = 4'd0;
    logic              in_cf = 1'b0, in_zf = 1'b0, in_sf = 1'b0, in_of = 1'b0, in_pf = 1'b0;
    logic              out_valid;
    logic              out_taken;
    logic [COST_W-1:0] out_cycles;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bcc_eval dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cond(in_cond),
        .in_cf(in_cf), .in_zf(in_zf), .in_sf(in_sf), .in_of(in_of), .in_pf(in_pf),
        .out_valid(out_valid), .out_taken(out_taken), .out_cycles(out_cycles)
    );

    function automatic bit ref_taken(input int code, input bit cf, zf, sf, of, pf);
        case (code)
            0:  return of;
            1:  return !of;
            2:  return cf;
            3:  return !cf;
            4:  return zf;
            5:  return !zf;
            6:  return cf || zf;
            7:  return !cf && !zf;
            8:  return sf;
            9:  return !sf;
            10: return pf;
            11: return !pf;
            12: return sf != of;
            13: return sf == of;
            14: return zf || (sf != of);
            default: return !zf && (sf == of);
        endcase
    endfunction

    function automatic string req_tag(input int code);
        case (code / 2)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            6: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one request and check the result one cycle later
    task automatic issue(input int code, input bit cf, zf, sf, of, pf, output bit got);
        bit exp_t;
        @(negedge clk);
        in_valid = 1'b1; in_cond = 4'(code);
        in_cf = cf; in_zf = zf; in_sf = sf; in_of = of; in_pf = pf;
        exp_t = ref_taken(code, cf, zf, sf, of, pf);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R2", int'(out_valid), 1);
        check(out_taken == exp_t, req_tag(code), int'(out_taken), int'(exp_t));
        check(out_cycles == (exp_t ? 16 : 4), "R12", int'(out_cycles), exp_t ? 16 : 4);
        got = out_taken;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit t0, t1;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(out_taken == 1'b0, "R1", int'(out_taken), 0);
        check(out_cycles == 0, "R1", int'(out_cycles), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R2", int'(out_valid), 0);

        // Directed: every code against every flag pattern; R11 pair complement
        for (int f = 0; f < 32; f++) begin
            for (int k = 0; k < 8; k++) begin
                issue(2*k,   f[4], f[3], f[2], f[1], f[0], t0);
                issue(2*k+1, f[4], f[3], f[2], f[1], f[0], t1);
                check(t0 != t1, "R11", int'(t1), int'(!t0));
            end
        end

        // Random requests with idle gaps and scrambled idle inputs
        for (int i = 0; i < 400; i++) begin
            bit [4:0] fl;
            bit       g;
            bit [COST_W-1:0] hc;
            fl = 5'($urandom);
            issue(int'($urandom % 16), fl[4], fl[3], fl[2], fl[1], fl[0], g);
            if (($urandom % 3) == 0) begin
                hc = out_cycles;
                @(negedge clk);
                in_valid = 1'b0;
                in_cond = 4'($urandom);
                {in_cf, in_zf, in_sf, in_of, in_pf} = 5'($urandom);
                @(negedge clk);
                check(out_valid == 1'b0, "R2", int'(out_valid), 0);
                check(out_taken == g, "R13", int'(out_taken), int'(g));
                check(out_cycles == hc, "R13", int'(out_cycles), int'(hc));
            end
        end

        // Back-to-back requests without gaps
        for (int i = 0; i < 16; i++) begin
            bit e;
            @(negedge clk);
            in_valid = 1'b1; in_cond = 4'(i);
            {in_cf, in_zf, in_sf, in_of, in_pf} = 5'b01010;
            e = ref_taken(i, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
            @(posedge clk);
            #1;
            check(out_valid == 1'b1, "R2", int'(out_valid), 1);
            check(out_taken == e, req_tag(i), int'(out_taken), int'(e));
        end
        @(negedge clk);
        in_valid = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule